// File: doc/BRIEF.md
# Bit-Serial Systolic Multiply-Accumulate Array

This block multiplies two unsigned N-bit operands that arrive one bit per clock, least significant bit first, and adds an optional N-bit addend that arrives the same way. It streams out the 2N-bit result `addend + a*b`, least significant bit first, one bit per clock. It uses a linear chain of exactly N identical processing elements and finishes one operation in 2N compute steps.

Each element keeps one bit of each operand, and it captures those bits from the serial inputs at its own step. At every later step it forms the two cross products of its stored bits with the bits currently broadcast on the inputs. It adds these two products, the sum arriving from the element above, its own first-order carry and the second-order carry arriving from the element below. A five-input counter does the addition. Sum bits move one element toward the output, first-order carries stay in place, and second-order carries move one element away from the output. The addend enters through the second-order-carry input of element 0.

A one-cycle `start` pulse clears the array and begins an operation. In the k-th cycle after the pulse (k = 0..N-1) the user presents operand and addend bit k. The result bits then leave on `r_out` while `r_valid` is high.

Top module: `bsmac_top`

## Requirements
- R1: While `rst_n` is low, and after reset until the first `start`, `r_valid` and `r_out` are 0.
- R2: After `start` is high at a rising edge, `r_valid` stays low for one cycle. It is then high for exactly 2N consecutive cycles and then low again.
- R3: In the j-th cycle (j = 0..2N-1) in which `r_valid` is high, `r_out` equals bit j of `addend + a*b`, computed as an unsigned 2N-bit value.
- R4: Bit k of `a_in`, `b_in` and `add_in` (weight 2^k) is taken in the cycle k+1 after the cycle in which `start` was sampled, for k = 0..N-1.
- R5: Values on `a_in`, `b_in` and `add_in` in compute steps N..2N-1, and in idle cycles, have no effect on the result.
- R6: Corner operands give exact results: all zeros, all ones on every input (giving 2^2N - 2^N), a zero addend (pure product) and zero operands (the addend alone).
- R7: A `start` pulse during an operation abandons it. The new operation then produces its full, correct result with no residue from the old one.
- R8: `r_out` is 0 in every cycle in which `r_valid` is low.
- R9: Each element's counter output {d,c,s}, read as a binary number, equals the number of ones among its five inputs.
- R10: An element's stored operand bits change only on `start` or in the element's own capture step.
- R11: Once the last result bit is on the output, every carry register and every sum register except the output element's holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that clears the array and begins an operation |
| a_in | input | 1 | Serial multiplicand, LSB first |
| b_in | input | 1 | Serial multiplier, LSB first |
| add_in | input | 1 | Serial addend, LSB first |
| r_out | output | 1 | Serial result, LSB first |
| r_valid | output | 1 | High while `r_out` carries a result bit |

## Verification
The embedded assertions check several properties on every cycle: the counter arithmetic in each element, that stored operand bits do not change outside their capture step, that the result window opens two cycles after a start, and that the array is fully drained when the last bit leaves. Only the bench's scenarios can show that the serialized bits form the correct sum and product. The same holds for the exact window length, for garbage on the inputs during the drain being ignored, and for a restart in mid-operation leaving no residue. The bench's reference model compares every output cycle against these.

// File: rtl/bsmac_pkg.sv
package bsmac_pkg;

  typedef struct packed {
    logic d;  // weight 4
    logic c;  // weight 2
    logic s;  // weight 1
  } cnt53_t;

  // Five-input counter: binary count of ones, three bits.
  function automatic cnt53_t cnt53(input logic [4:0] x);
    logic [2:0] n;
    cnt53_t     o;
    n = 3'd0;
    for (int i = 0; i < 5; i++) n = n + {2'b00, x[i]};
    o.s = n[0];
    o.c = n[1];
    o.d = n[2];
    return o;
  endfunction

endpackage

// File: rtl/bsmac_seq.sv
module bsmac_seq #(
  parameter int N  = 8,
  parameter int SW = $clog2(2*N+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [SW-1:0] step,
  output logic          comp_en,
  output logic          feed_en,
  output logic          last_out,
  output logic          r_valid
);
  localparam logic [SW-1:0] STEP_END  = SW'(2*N);
  localparam logic [SW-1:0] STEP_FEED = SW'(N);

  logic busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (start) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy) begin
      if (step == STEP_END) busy <= 1'b0;
      else                  step <= step + 1'b1;
    end
  end

  assign comp_en  = busy && (step < STEP_END);
  assign feed_en  = comp_en && (step < STEP_FEED);
  assign r_valid  = busy && (step != '0);
  assign last_out = busy && (step == STEP_END);

  AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_valid) |-> $past(start, 2));  // R2

  AST_FEED_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    feed_en |-> r_valid || $past(start));  // R4

endmodule

// File: rtl/bsmac_pe.sv
module bsmac_pe
  import bsmac_pkg::*;
#(
  parameter int N   = 8,
  parameter int IDX = 0,
  parameter int SW  = $clog2(2*N+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          comp_en,
  input  logic [SW-1:0] step,
  input  logic          a_bc,
  input  logic          b_bc,
  input  logic          sum_in,
  input  logic          d_in,
  output logic          sum_q,
  output logic          c_q,
  output logic          d_q
);
  localparam logic [SW-1:0] MY_STEP = SW'(IDX);

  logic   a_h, b_h;
  logic   capture;
  logic   prod_x, prod_y;
  logic [4:0] cin;
  cnt53_t cout;

  assign capture = comp_en && (step == MY_STEP);
  // At the capture step only the diagonal product counts.
  assign prod_x  = capture ? (a_bc & b_bc) : (a_h & b_bc);
  assign prod_y  = capture ? 1'b0          : (a_bc & b_h);
  assign cin     = {prod_x, prod_y, sum_in, c_q, d_in};
  assign cout    = cnt53(cin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {a_h, b_h, sum_q, c_q, d_q} <= '0;
    end else if (clr) begin
      {a_h, b_h, sum_q, c_q, d_q} <= '0;
    end else if (comp_en) begin
      sum_q <= cout.s;
      c_q   <= cout.c;
      d_q   <= cout.d;
      if (capture) begin
        a_h <= a_bc;
        b_h <= b_bc;
      end
    end
  end

  AST_CNT53_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    comp_en |-> ({29'd0, cout.d, cout.c, cout.s} == 32'($countones(cin))));  // R9

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !capture) |=> ($stable(a_h) && $stable(b_h)));  // R10

endmodule

// File: rtl/bsmac_top.sv
module bsmac_top #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic a_in,
  input  logic b_in,
  input  logic add_in,
  output logic r_out,
  output logic r_valid
);
  localparam int SW = $clog2(2*N+1);

  logic [SW-1:0] step;
  logic          comp_en, feed_en, last_out;
  logic          a_bc, b_bc, add_bc;
  logic [N-1:0]  sum_q, c_q, d_q, sum_in, d_in;
  logic          array_idle;

  bsmac_seq #(.N(N), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .step(step), .comp_en(comp_en), .feed_en(feed_en),
    .last_out(last_out), .r_valid(r_valid)
  );

  // Broadcast inputs are forced to zero outside the feed steps.
  assign a_bc   = feed_en & a_in;
  assign b_bc   = feed_en & b_in;
  assign add_bc = feed_en & add_in;

  for (genvar p = 0; p < N; p++) begin : g_pe
    if (p == N-1) begin : g_top_sum
      assign sum_in[p] = 1'b0;
    end else begin : g_mid_sum
      assign sum_in[p] = sum_q[p+1];
    end
    if (p == 0) begin : g_add
      assign d_in[p] = add_bc;
    end else begin : g_chain_d
      assign d_in[p] = d_q[p-1];
    end

    bsmac_pe #(.N(N), .IDX(p), .SW(SW)) u_pe (
      .clk(clk), .rst_n(rst_n), .clr(start), .comp_en(comp_en),
      .step(step), .a_bc(a_bc), .b_bc(b_bc),
      .sum_in(sum_in[p]), .d_in(d_in[p]),
      .sum_q(sum_q[p]), .c_q(c_q[p]), .d_q(d_q[p])
    );
  end

  assign r_out      = r_valid & sum_q[0];
  assign array_idle = ~(|c_q) & ~(|d_q) & ~(|sum_q[N-1:1]);

  AST_ARRAY_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    last_out |-> array_idle);  // R11

  AST_QUIET_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !r_valid |-> !r_out);  // R8

endmodule

// File: tb/tb_bsmac_top.sv
module tb_bsmac_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic a_in = 1'b0, b_in = 1'b0, add_in = 1'b0;
  logic r_out, r_valid;
  int   n_chk = 0;
  int   n_bad = 0;

  bsmac_top #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_in(a_in), .b_in(b_in), .add_in(add_in),
    .r_out(r_out), .r_valid(r_valid)
  );

  always #10ns clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One operation. Inputs change on falling edges; outputs are compared on
  // falling edges, half a cycle after the rising edge that updated them.
  // stop_at < 2N+2 abandons the operation early (R7).
  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                        input logic [N-1:0] s, input bit junk, input int stop_at);
    logic [2*N-1:0] exp;
    exp = (2*N)'(a) * (2*N)'(b) + (2*N)'(s);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int m = 1; m <= 2*N+2; m++) begin
      if (m > stop_at) break;
      if (m != 1) @(negedge clk);
      begin
        logic ev, eo;
        ev = (m >= 2) && (m <= 2*N+1);
        eo = ev ? exp[(m >= 2) ? m-2 : 0] : 1'b0;
        check("R2 r_valid window", r_valid, ev);
        check(ev ? "R3 result bit" : "R8 quiet output", r_out, eo);
      end
      // R4: bit k is driven for the cycle k+1 after start is sampled.
      if (m <= N) begin
        a_in = a[m-1]; b_in = b[m-1]; add_in = s[m-1];
      end else if (junk) begin  // R5: garbage during drain
        a_in = 1'($urandom); b_in = 1'($urandom); add_in = 1'($urandom);
      end else begin
        a_in = 1'b0; b_in = 1'b0; add_in = 1'b0;
      end
    end
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", r_valid, 1'b0);
    check("R1 out in reset", r_out, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid idle", r_valid, 1'b0);
    check("R1 out idle", r_out, 1'b0);

    // R6 corners
    run_op('0, '0, '0, 1'b0, 2*N+2);
    run_op('1, '1, '1, 1'b0, 2*N+2);
    run_op('1, '1, '0, 1'b1, 2*N+2);
    run_op('0, '0, '1, 1'b1, 2*N+2);
    run_op('1, 8'd1, '0, 1'b0, 2*N+2);
    run_op(8'h80, 8'h80, 8'h01, 1'b1, 2*N+2);
    // R3/R5 random, garbage during drain
    for (int i = 0; i < 40; i++)
      run_op(N'($urandom), N'($urandom), N'($urandom), 1'b1, 2*N+2);
    // R7: abandon mid-operation, then a full one
    run_op('1, '1, '1, 1'b1, N+1);
    run_op(8'h5a, 8'hc3, 8'h77, 1'b0, 2*N+2);
    run_op('1, '1, '1, 1'b0, 3);
    run_op(8'h0f, 8'hf0, 8'h00, 1'b1, 2*N+2);
    // R5: idle-time inputs must not start or disturb anything
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      a_in = 1'b1; b_in = 1'b1; add_in = 1'b1;
      check("R5 idle valid", r_valid, 1'b0);
      check("R5 idle out", r_out, 1'b0);
    end
    run_op(8'h03, 8'h05, 8'h02, 1'b0, 2*N+2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule